// File: doc/BRIEF.md
# Event Queue Interrupt Notifier

This block appends fault records to a circular queue held in memory and tells software when fresh records are waiting. It owns the producer index of that queue and watches the consumer index, which software advances. Each record arrives on a valid/ready port. The block writes the record to memory as a burst of 64-bit beats over a request/acknowledge port. Once the last beat is acknowledged, it advances the producer index.

The notification is edge-like. It is raised only when a record lands in a queue that held no unconsumed entries at the moment the record was accepted. It can go out as a one-cycle pulse on a wired line, as a 32-bit message write to a programmed address, or as both. The message write needs message capability in the ID register and a non-zero target address.

When the queue is full, the record is dropped and a sticky overflow flag is set. The next successful append clears the flag. Queue geometry, interrupt enables, capability bits and the message configuration are plain register inputs.

Top module: `evtq_notify`

## Requirements
- R1: After reset, `prod_idx` is 0, `mem_req`, `irq_wire` and `ovf_flag` are low, and `evt_ready` is high.
- R2: Each accepted record is written as four 64-bit beats, with `mem_is32` low. Beat k goes to address base + 32*producer + 8*k and carries `evt_data[64k+63:64k]`. Each beat stays presented until `mem_ack`. `evt_ready` is low from acceptance until the last write of the event completes.
- R3: The queue base is `q_base[47:5]` with the low five address bits zero. The queue holds 2^n entries, where n = `q_base[4:0]` limited to `IDX_W`. One cycle after the last beat's acknowledge, `prod_idx` becomes (producer+1) mod 2^n.
- R4: An event is dropped when ((producer+1) mod 2^n) equals (consumer mod 2^n). A dropped event causes no write and no interrupt, leaves `prod_idx` unchanged, and sets `ovf_flag` in the next cycle. `ovf_flag` holds until the next record completes, and clears in that same cycle.
- R5: A notification is due only when producer mod 2^n equals consumer mod 2^n at acceptance and `irq_ctrl[2]` is set. `irq_ctrl[0]` and `irq_ctrl[1]` have no effect.
- R6: For a due notification, one 32-bit write (`mem_is32` high) follows the record, but only if `id_reg[13]` is set and `{irq_cfg0[47:2],2'b00}` is non-zero. It goes to that address with data `{32'b0, irq_cfg1}`. Otherwise no message write is issued.
- R7: With `WIRED_EN` set, a due notification drives `irq_wire` high for exactly one cycle. That cycle directly follows the last record beat's acknowledge, whatever R6 decides.
- R8: No message write and no wired pulse is issued before the last beat of the record it announces has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A record is offered |
| evt_ready | output | 1 | Block can take a record |
| evt_data | input | REC_BEATS*64 | Record payload, beat 0 in the low bits |
| q_base | input | 64 | Queue base address and log2 of entry count |
| cons_idx | input | IDX_W | Consumer index from software |
| irq_ctrl | input | 32 | Interrupt enables; bit 2 gates this path |
| id_reg | input | 32 | Capability bits; bit 13 is message capability |
| irq_cfg0 | input | 64 | Message target address in bits [47:2] |
| irq_cfg1 | input | 32 | Message payload |
| mem_req | output | 1 | Memory write request |
| mem_ack | input | 1 | Memory write accepted |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 64 | Write data |
| mem_is32 | output | 1 | High for the 32-bit message write |
| prod_idx | output | IDX_W | Producer index |
| ovf_flag | output | 1 | Sticky overflow status |
| irq_wire | output | 1 | Wired interrupt pulse |

## Verification
Three things can meet in the same cycle:
- the acknowledge of the last record beat, which advances the producer, clears overflow and pulses the wire;
- a consumer index update that empties or fills the queue;
- a pending offer that is judged against the producer value the last beat is about to commit.

The bench provokes these collisions by stalling the acknowledge at random, moving the consumer index every 37 cycles with junk in the unused upper bits, and holding `evt_valid` high continuously. A behavioural reference model judges each event at the cycle it is accepted. It predicts the write stream, the producer value, the overflow flag and the pulse cycle, and compares all of them against the ports every clock.

// File: rtl/evtq_notify.sv
module evtq_notify #(
  parameter int ADDR_W    = 48,
  parameter int IDX_W     = 20,
  parameter int REC_BEATS = 4,
  parameter bit WIRED_EN  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_valid,
  output logic                    evt_ready,
  input  logic [REC_BEATS*64-1:0] evt_data,
  input  logic [63:0]             q_base,
  input  logic [IDX_W-1:0]        cons_idx,
  input  logic [31:0]             irq_ctrl,
  input  logic [31:0]             id_reg,
  input  logic [63:0]             irq_cfg0,
  input  logic [31:0]             irq_cfg1,
  output logic                    mem_req,
  input  logic                    mem_ack,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [63:0]             mem_wdata,
  output logic                    mem_is32,
  output logic [IDX_W-1:0]        prod_idx,
  output logic                    ovf_flag,
  output logic                    irq_wire
);
  localparam int BEAT_W    = (REC_BEATS > 1) ? $clog2(REC_BEATS) : 1;
  localparam int REC_SHIFT = $clog2(REC_BEATS * 8);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(REC_BEATS - 1);

  typedef enum logic [1:0] {S_IDLE, S_REC, S_MSI} st_t;

  st_t                    st;
  logic [BEAT_W-1:0]      beat;
  logic [REC_BEATS*64-1:0] rec;
  logic [ADDR_W-1:0]      rec_addr_q;
  logic                   notify_q;
  logic [IDX_W-1:0]       prod;

  logic [4:0]       lg;
  logic [IDX_W:0]   span;
  logic [IDX_W-1:0] mask, prod_m, cons_m, prod_nx;
  logic [ADDR_W-1:0] base, rec_addr, msi_addr;
  logic              is_empty, is_full, msi_ok, take, last_done;
  logic              unused_bits;

  assign lg       = (q_base[4:0] > 5'(IDX_W)) ? 5'(IDX_W) : q_base[4:0];
  assign span     = (IDX_W+1)'(1) << lg;
  assign mask     = IDX_W'(span - 1'b1);
  assign prod_m   = prod & mask;
  assign cons_m   = cons_idx & mask;
  assign prod_nx  = (prod_m + 1'b1) & mask;
  assign is_empty = prod_m == cons_m;
  assign is_full  = prod_nx == cons_m;

  assign base     = {q_base[ADDR_W-1:5], 5'b0};
  assign rec_addr = base + (ADDR_W'(prod_m) << REC_SHIFT);
  assign msi_addr = {irq_cfg0[ADDR_W-1:2], 2'b00};
  assign msi_ok   = id_reg[13] && (msi_addr != '0);

  assign take      = (st == S_IDLE) && evt_valid;
  assign last_done = (st == S_REC) && mem_ack && (beat == LAST_BEAT);

  assign unused_bits = ^{irq_ctrl[31:3], irq_ctrl[1:0], id_reg[31:14], id_reg[12:0],
                         q_base[63:ADDR_W], irq_cfg0[63:ADDR_W], irq_cfg0[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      beat       <= '0;
      rec        <= '0;
      rec_addr_q <= '0;
      notify_q   <= 1'b0;
      prod       <= '0;
      ovf_flag   <= 1'b0;
      irq_wire   <= 1'b0;
    end else begin
      irq_wire <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (is_full) begin
            ovf_flag <= 1'b1;
          end else begin
            rec        <= evt_data;
            rec_addr_q <= rec_addr;
            notify_q   <= is_empty && irq_ctrl[2];
            beat       <= '0;
            st         <= S_REC;
          end
        end
        S_REC: if (mem_ack) begin
          if (last_done) begin
            prod     <= prod_nx;
            ovf_flag <= 1'b0;
            irq_wire <= notify_q && WIRED_EN;
            st       <= (notify_q && msi_ok) ? S_MSI : S_IDLE;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        S_MSI: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign evt_ready = (st == S_IDLE);
  assign mem_req   = (st != S_IDLE);
  assign mem_is32  = (st == S_MSI);
  assign mem_addr  = (st == S_MSI) ? msi_addr
                                   : rec_addr_q + (ADDR_W'(beat) << 3);
  assign mem_wdata = (st == S_MSI) ? {32'b0, irq_cfg1} : rec[beat*64 +: 64];
  assign prod_idx  = prod;
endmodule

// File: rtl/evtq_notify_chk.sv
module evtq_notify_chk #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_is32,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       id_reg,
  input logic [IDX_W-1:0]  prod_idx,
  input logic              ovf_flag,
  input logic              irq_wire
);
  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !evt_ready);

  p_hold_until_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_is32));

  p_prod_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prod_idx) |-> $past(mem_req && mem_ack && !mem_is32));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(evt_valid && evt_ready) && $stable(prod_idx));

  p_msi_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_is32 |-> id_reg[13] && (mem_addr != '0) && (mem_addr[1:0] == 2'b00));

  p_pulse_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wire |=> !irq_wire);

  p_pulse_after_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wire |-> $past(mem_req && mem_ack && !mem_is32));
endmodule

bind evtq_notify evtq_notify_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_evtq_notify.sv
module test_evtq_notify;
  localparam int ADDR_W = 48;
  localparam int IDX_W  = 20;
  localparam int BEATS  = 4;
  localparam int PHASE  = 300;
  localparam int NPH    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic evt_ready;
  logic [BEATS*64-1:0] evt_data = '0;
  logic [63:0] q_base = '0;
  logic [IDX_W-1:0] cons_idx = '0;
  logic [31:0] irq_ctrl = '0, id_reg = '0, irq_cfg1 = '0;
  logic [63:0] irq_cfg0 = '0;
  logic mem_req, mem_ack = 1'b0, mem_is32, ovf_flag, irq_wire;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [IDX_W-1:0] prod_idx;

  always #5 clk = ~clk;

  evtq_notify #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .REC_BEATS(BEATS), .WIRED_EN(1'b1)) i_evtq_notify (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_data(evt_data), .q_base(q_base), .cons_idx(cons_idx), .irq_ctrl(irq_ctrl),
    .id_reg(id_reg), .irq_cfg0(irq_cfg0), .irq_cfg1(irq_cfg1), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_is32(mem_is32),
    .prod_idx(prod_idx), .ovf_flag(ovf_flag), .irq_wire(irq_wire));

  typedef struct {
    logic [47:0] a;
    logic [63:0] d;
    bit w32;
    bit last;
    bit ntf;
    int nx;
  } wr_t;

  wr_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int m_prod = 0, n_prod = 0;
  bit m_ovf = 0, n_ovf = 0, m_irq = 0, n_irq = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic accept();
    int lg, mask, pm, cm, nx;
    bit ntf, msi;
    logic [47:0] base, madr;
    lg   = (int'(q_base[4:0]) > IDX_W) ? IDX_W : int'(q_base[4:0]);
    mask = (1 << lg) - 1;
    pm   = m_prod & mask;
    cm   = int'(cons_idx) & mask;
    nx   = (pm + 1) & mask;
    if (nx == cm) begin
      n_ovf = 1'b1;
      return;
    end
    ntf  = (pm == cm) && irq_ctrl[2];
    base = q_base[47:0] & 48'hFFFF_FFFF_FFE0;
    madr = irq_cfg0[47:0] & 48'hFFFF_FFFF_FFFC;
    msi  = ntf && id_reg[13] && (madr != '0);
    for (int k = 0; k < BEATS; k++) begin
      wr_t e;
      e.a = base + 48'(pm) * 48'd32 + 48'(k * 8);
      e.d = evt_data[k*64 +: 64];
      e.w32 = 1'b0;
      e.last = (k == BEATS - 1);
      e.ntf = ntf;
      e.nx = nx;
      exp_q.push_back(e);
    end
    if (msi) begin
      wr_t e;
      e.a = madr;
      e.d = {32'b0, irq_cfg1};
      e.w32 = 1'b1;
      e.last = 1'b0;
      e.ntf = 1'b0;
      e.nx = 0;
      exp_q.push_back(e);
    end
  endtask

  task automatic set_phase(input int ph);
    case (ph)
      0: begin q_base = 64'h0000_0000_8000_0002; irq_ctrl = 32'h7; id_reg = 32'h2000;
               irq_cfg0 = 64'h0000_00AB_CDEF_0123; irq_cfg1 = 32'hC0DE_0001; end
      1: begin q_base = 64'hFFFF_0001_2340_0003; irq_ctrl = 32'h3; end
      2: begin irq_ctrl = 32'h4; id_reg = 32'hFFFF_DFFF; end
      3: begin id_reg = 32'h2000; irq_cfg0 = 64'hFFFF_0000_0000_0003; end
      4: begin q_base = 64'h0000_0000_4000_0005; id_reg = 32'hFFFF_FFFF;
               irq_cfg0 = 64'h0000_0000_1000_0004; irq_cfg1 = 32'h5A5A_0042; end
      default: begin q_base = 64'h0000_0000_9000_0000; end
    endcase
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values before the first active edge after release
    chk(prod_idx == '0, "R1 prod_idx", 64'(prod_idx), 0);
    chk(!mem_req, "R1 mem_req", 64'(mem_req), 0);
    chk(!irq_wire, "R1 irq_wire", 64'(irq_wire), 0);
    chk(!ovf_flag, "R1 ovf_flag", 64'(ovf_flag), 0);
    chk(evt_ready, "R1 evt_ready", 64'(evt_ready), 1);
    for (int cyc = 0; cyc < PHASE * NPH; cyc++) begin
      int ph, loc;
      @(negedge clk);
      m_prod = n_prod; m_ovf = n_ovf; m_irq = n_irq; n_irq = 1'b0;
      chk(evt_ready == (exp_q.size() == 0), "R2 evt_ready", 64'(evt_ready), 64'(exp_q.size() == 0));
      chk(int'(prod_idx) == m_prod, "R3 prod_idx", 64'(prod_idx), 64'(m_prod));
      chk(ovf_flag == m_ovf, "R4 ovf_flag", 64'(ovf_flag), 64'(m_ovf));
      chk(irq_wire == m_irq, "R5 R7 irq_wire", 64'(irq_wire), 64'(m_irq));
      ph  = cyc / PHASE;
      loc = cyc % PHASE;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (loc == 0) set_phase(ph);
      mem_ack   = (ph == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      evt_valid = (loc < PHASE - 40) && ((ph == 4) ? lfsr[5] : 1'b1);
      for (int k = 0; k < BEATS; k++) evt_data[k*64 +: 64] = {32'(cyc), 32'(k) ^ 32'hF00D_0000};
      if (ph != 0 && loc % 37 == 5) cons_idx = IDX_W'(m_prod) | {lfsr[7:4], 16'b0};
      #1;
      if (mem_req && mem_ack) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected write", 64'(mem_addr), 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          // R2 record beats, R6 message write, R8 order given by queue position
          chk(mem_is32 == e.w32, e.w32 ? "R6 R8 write kind" : "R2 write kind", 64'(mem_is32), 64'(e.w32));
          chk(mem_addr == e.a, e.w32 ? "R6 address" : "R2 address", 64'(mem_addr), 64'(e.a));
          chk(mem_wdata == e.d, e.w32 ? "R6 data" : "R2 data", mem_wdata, e.d);
          if (e.last) begin
            n_prod = e.nx;
            n_ovf  = 1'b0;
            n_irq  = e.ntf;
          end
        end
      end else if (evt_valid && evt_ready) begin
        accept();
      end
    end
    chk(exp_q.size() == 0, "R2 R6 writes outstanding", 64'(exp_q.size()), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2 actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule